// File: doc/BRIEF.md
# Programmable Parallel Port Controller

The block gives a processor three byte-wide parallel ports, called A, B and C, behind a small bus interface. The bus has a chip select, a read strobe and a write strobe, all active low. A two-bit register select picks the target, and data enters and leaves on separate input and output bytes. Each port line has a pin input, a latched output value and an output enable. Port C is split into a high half and a low half of four bits each.

Software configures the ports by writing a command byte to the control address. Bit 7 of that byte decides what the command does. When bit 7 is set, the byte is a configuration word. It sets the direction of A, of B and of each half of C, and it also sets the two group mode fields. When bit 7 is clear, the byte sets or clears a single line of port C and changes nothing else.

In simple I/O mode, a port set as output holds the last byte written to it. A port set as input is read straight from its pins, with no latch in between. The handshaked modes are not carried out here. Their mode fields are only exported, for a separate handshake block to use.

Top module: `pario_ctrl`

## Requirements
- R1: After reset the configuration word reads back as 0x9B: every port is an input with all output enables low, both mode fields are 0, and all output latches are 0.
- R2: The register select addresses port A at 0, port B at 1, port C at 2 and the control register at 3.
- R3: A control write with bit 7 = 1 sets the directions: bit 4 for port A, bit 1 for port B, bit 3 for the C high half and bit 0 for the C low half. A 1 means input (enables low) and a 0 means output (enables high). For example, 0x82 makes B an input and A and C outputs.
- R4: A configuration write drives the group A mode output from bits 6..5 and the group B mode output from bit 2.
- R5: A configuration write clears the A, B and C output latches to 0.
- R6: A control write with bit 7 = 0 writes bit 0 into port C line number bits 3..1. All other C lines, the directions and the modes are unchanged. For example, 0x0F sets line 7.
- R7: A write to port A, B or C loads that port's output latch. The latch drives the port's output and keeps its value until the next write to it.
- R8: A read of port A or B returns the latch when the port is an output and the pins when it is an input. Port C chooses between latch and pins separately for each half.
- R9: A read of the control address returns the last configuration word.
- R10: The data output is 0 unless both chip select and read strobe are low.
- R11: With chip select high, a low write strobe changes no latch, direction or mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, sampled on the clock |
| sel | input | 2 | Register select |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor |
| pa_in | input | 8 | Port A pins |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pins |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pins |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |
| grpa_mode | output | 2 | Group A mode field |
| grpb_mode | output | 1 | Group B mode field |

## Verification
The assertions assume that a write is a cycle in which chip select and write strobe are both low and that the write data is stable across the sampling edge. They also assume that read and write strobes are never low together. The bench changes every input on the falling clock edge and keeps the two strobes exclusive. Its random operations include idle cycles where chip select is high while the write strobe is low, which exercises R11 without breaking the bus rules above.

// File: rtl/pario_pkg.sv
package pario_pkg;
    localparam int PORT_W  = 8;
    localparam int HALF_W  = PORT_W / 2;
    localparam int SEL_W   = 2;
    localparam int IDX_W   = $clog2(PORT_W);
    localparam logic [PORT_W-1:0] CFG_RESET = 8'h9B;

    typedef enum logic [SEL_W-1:0] {
        SEL_A   = 2'd0,
        SEL_B   = 2'd1,
        SEL_C   = 2'd2,
        SEL_CTL = 2'd3
    } sel_e;

    typedef struct packed {
        logic [PORT_W-1:0] cfg;
        logic [PORT_W-1:0] la;
        logic [PORT_W-1:0] lb;
        logic [PORT_W-1:0] lc;
    } pario_state_t;
endpackage

// File: rtl/pario_cmd_decode.sv
module pario_cmd_decode
    import pario_pkg::*;
(
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [PORT_W-1:0] din,
    output logic              cfg_wr,
    output logic              bit_wr,
    output logic [2:0]        port_wr,
    output logic [IDX_W-1:0]  bit_idx,
    output logic              bit_val
);
    logic ctl_hit;

    always_comb begin
        ctl_hit = wr_en && (sel == SEL_CTL);
        cfg_wr  = ctl_hit && din[PORT_W-1];
        bit_wr  = ctl_hit && !din[PORT_W-1];
        bit_idx = din[IDX_W:1];
        bit_val = din[0];
        port_wr = '0;
        if (wr_en) begin
            unique case (sel)
                SEL_A:   port_wr[0] = 1'b1;
                SEL_B:   port_wr[1] = 1'b1;
                SEL_C:   port_wr[2] = 1'b1;
                default: port_wr    = '0;
            endcase
        end
    end
endmodule

// File: rtl/pario_cfg_map.sv
module pario_cfg_map
    import pario_pkg::*;
(
    input  logic [PORT_W-1:0] cfg,
    output logic [PORT_W-1:0] a_oe,
    output logic [PORT_W-1:0] b_oe,
    output logic [PORT_W-1:0] c_oe,
    output logic [1:0]        a_mode,
    output logic              b_mode
);
    // direction bit of each port C half: index 0 low, 1 high
    logic [1:0] c_dir;
    assign c_dir = {cfg[3], cfg[0]};

    assign a_oe   = {PORT_W{~cfg[4]}};
    assign b_oe   = {PORT_W{~cfg[1]}};
    assign a_mode = cfg[6:5];
    assign b_mode = cfg[2];

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign c_oe[h*HALF_W +: HALF_W] = {HALF_W{~c_dir[h]}};
    end
endmodule

// File: rtl/pario_rd_mux.sv
module pario_rd_mux
    import pario_pkg::*;
(
    input  logic              rd_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [PORT_W-1:0] cfg,
    input  logic [PORT_W-1:0] la,
    input  logic [PORT_W-1:0] lb,
    input  logic [PORT_W-1:0] lc,
    input  logic [PORT_W-1:0] a_oe,
    input  logic [PORT_W-1:0] b_oe,
    input  logic [PORT_W-1:0] c_oe,
    input  logic [PORT_W-1:0] pa_in,
    input  logic [PORT_W-1:0] pb_in,
    input  logic [PORT_W-1:0] pc_in,
    output logic [PORT_W-1:0] dout
);
    logic [PORT_W-1:0] va, vb, vc;

    for (genvar i = 0; i < PORT_W; i++) begin : g_line
        assign va[i] = a_oe[i] ? la[i] : pa_in[i];
        assign vb[i] = b_oe[i] ? lb[i] : pb_in[i];
        assign vc[i] = c_oe[i] ? lc[i] : pc_in[i];
    end

    always_comb begin
        dout = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_A:   dout = va;
                SEL_B:   dout = vb;
                SEL_C:   dout = vc;
                default: dout = cfg;
            endcase
        end
    end
endmodule

// File: rtl/pario_ctrl.sv
module pario_ctrl
    import pario_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic [PORT_W-1:0] din,
    output logic [PORT_W-1:0] dout,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic [PORT_W-1:0] pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic [PORT_W-1:0] pb_oe,
    input  logic [PORT_W-1:0] pc_in,
    output logic [PORT_W-1:0] pc_out,
    output logic [PORT_W-1:0] pc_oe,
    output logic [1:0]        grpa_mode,
    output logic              grpb_mode
);
    pario_state_t st_q, st_d;

    logic             wr_en, rd_en;
    logic             cfg_wr, bit_wr, bit_val;
    logic [2:0]       port_wr;
    logic [IDX_W-1:0] bit_idx;

    assign wr_en = !cs_n && !wr_n;
    assign rd_en = !cs_n && !rd_n;

    pario_cmd_decode u_dec (
        .wr_en   (wr_en),
        .sel     (sel),
        .din     (din),
        .cfg_wr  (cfg_wr),
        .bit_wr  (bit_wr),
        .port_wr (port_wr),
        .bit_idx (bit_idx),
        .bit_val (bit_val)
    );

    pario_cfg_map u_map (
        .cfg    (st_q.cfg),
        .a_oe   (pa_oe),
        .b_oe   (pb_oe),
        .c_oe   (pc_oe),
        .a_mode (grpa_mode),
        .b_mode (grpb_mode)
    );

    pario_rd_mux u_rd (
        .rd_en (rd_en),
        .sel   (sel),
        .cfg   (st_q.cfg),
        .la    (st_q.la),
        .lb    (st_q.lb),
        .lc    (st_q.lc),
        .a_oe  (pa_oe),
        .b_oe  (pb_oe),
        .c_oe  (pc_oe),
        .pa_in (pa_in),
        .pb_in (pb_in),
        .pc_in (pc_in),
        .dout  (dout)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.cfg = din;
            st_d.la  = '0;
            st_d.lb  = '0;
            st_d.lc  = '0;
        end else if (bit_wr) begin
            st_d.lc[bit_idx] = bit_val;
        end else begin
            if (port_wr[0]) st_d.la = din;
            if (port_wr[1]) st_d.lb = din;
            if (port_wr[2]) st_d.lc = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg <= CFG_RESET;
            st_q.la  <= '0;
            st_q.lb  <= '0;
            st_q.lc  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pa_out = st_q.la;
    assign pb_out = st_q.lb;
    assign pc_out = st_q.lc;

    // R5
    cfg_clears_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && sel == 2'd3 && din[7]) |=>
            (pa_out == '0 && pb_out == '0 && pc_out == '0));

    // R6
    bit_op_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && sel == 2'd3 && !din[7]) |=>
            ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) &&
             $stable(grpa_mode) && $stable(grpb_mode) && $stable(pa_out) && $stable(pb_out)));

    // R6
    bit_op_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && sel == 2'd3 && !din[7]) |=>
            (pc_out[$past(din[3:1])] == $past(din[0])));

    // R7
    port_a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && sel == 2'd0) |=> (pa_out == $past(din)));

    // R11
    deselect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
                  $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) && $stable(grpa_mode)));

    // R10
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (dout == '0));
endmodule

// File: tb/pario_ctrl_bench.sv
module pario_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] sel = '0;
    logic [7:0] din = '0, dout;
    logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
    logic [1:0] grpa_mode;
    logic       grpb_mode;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [7:0] m_cfg, m_la, m_lb, m_lc;

    always #(CLK_PERIOD/2) clk = ~clk;

    pario_ctrl u_pario_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .sel(sel), .din(din), .dout(dout),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
        .grpa_mode(grpa_mode), .grpb_mode(grpb_mode)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_oe(input logic [7:0] c, input int p);
        if (p == 0) return {8{~c[4]}};
        if (p == 1) return {8{~c[1]}};
        return {{4{~c[3]}}, {4{~c[0]}}};
    endfunction

    function automatic logic [7:0] exp_rd(input logic [1:0] s);
        logic [7:0] oe;
        case (s)
            2'd0: begin oe = exp_oe(m_cfg, 0); return (m_la & oe) | (pa_in & ~oe); end
            2'd1: begin oe = exp_oe(m_cfg, 1); return (m_lb & oe) | (pb_in & ~oe); end
            2'd2: begin oe = exp_oe(m_cfg, 2); return (m_lc & oe) | (pc_in & ~oe); end
            default: return m_cfg;
        endcase
    endfunction

    task automatic model_wr(input logic [1:0] s, input logic [7:0] d);
        case (s)
            2'd0: m_la = d;
            2'd1: m_lb = d;
            2'd2: m_lc = d;
            default: begin
                if (d[7]) begin m_cfg = d; m_la = 0; m_lb = 0; m_lc = 0; end
                else m_lc[d[3:1]] = d[0];
            end
        endcase
    endtask

    task automatic check_state(input string req);
        chk({req, " pa_out"}, pa_out, m_la);
        chk({req, " pb_out"}, pb_out, m_lb);
        chk({req, " pc_out"}, pc_out, m_lc);
        chk({req, " pa_oe"}, pa_oe, exp_oe(m_cfg, 0));
        chk({req, " pb_oe"}, pb_oe, exp_oe(m_cfg, 1));
        chk({req, " pc_oe"}, pc_oe, exp_oe(m_cfg, 2));
        chk({req, " grpa_mode"}, {6'd0, grpa_mode}, {6'd0, m_cfg[6:5]});
        chk({req, " grpb_mode"}, {7'd0, grpb_mode}, {7'd0, m_cfg[2]});
    endtask

    task automatic bus_wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        sel = s; din = d; cs_n = 0; wr_n = 0;
        @(negedge clk);
        cs_n = 1; wr_n = 1;
        model_wr(s, d);
    endtask

    task automatic bus_rd(input logic [1:0] s, input string req);
        @(negedge clk);
        sel = s; cs_n = 0; rd_n = 0;
        #1 chk(req, dout, exp_rd(s));
        #1 cs_n = 1; rd_n = 1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_cfg = 8'h9B; m_la = 0; m_lb = 0; m_lc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check_state("R1");
        bus_rd(2'd3, "R1 R9 reset cfg readback");
        // R10 idle bus
        #1 chk("R10 idle dout", dout, 8'h00);

        // R3 0x82: B input, A and C output
        bus_wr(2'd3, 8'h82);
        check_state("R3 0x82");
        chk("R3 pb_oe input", pb_oe, 8'h00);
        chk("R3 pa_oe output", pa_oe, 8'hFF);
        // R2 R7 port writes
        bus_wr(2'd0, 8'hA5);
        bus_wr(2'd2, 8'h3C);
        check_state("R7 latch");
        pb_in = 8'h5A;
        bus_rd(2'd0, "R2 R8 read A latch");
        bus_rd(2'd1, "R2 R8 read B pins");
        bus_rd(2'd2, "R2 R8 read C latch");
        // R5 mode set clears latches
        bus_wr(2'd3, 8'h80);
        check_state("R5 clear");
        chk("R5 pa_out zero", pa_out, 8'h00);
        // R6 0x0F sets PC7
        bus_wr(2'd3, 8'h0F);
        chk("R6 PC7 set", pc_out, 8'h80);
        bus_wr(2'd3, 8'h04);
        chk("R6 PC2 clear keeps PC7", pc_out, 8'h80);
        bus_rd(2'd3, "R9 cfg after bit op");
        // R4 modes
        bus_wr(2'd3, 8'hE4);
        check_state("R4 modes");
        chk("R4 grpa mode2", {6'd0, grpa_mode}, 8'h03);
        // R8 port C halves split
        bus_wr(2'd3, 8'h81);
        bus_wr(2'd2, 8'hC3);
        pc_in = 8'h96;
        bus_rd(2'd2, "R8 C low in high out");
        // R11 deselected write ignored
        @(negedge clk); sel = 2'd0; din = 8'h77; cs_n = 1; wr_n = 0;
        @(negedge clk); wr_n = 1;
        check_state("R11 deselected");

        process::self().srandom(32'd1234);
        for (int n = 0; n < 400; n++) begin
            int op = $urandom_range(0, 4);
            logic [1:0] s = 2'($urandom_range(0, 3));
            logic [7:0] d = 8'($urandom);
            case (op)
                0, 1: begin bus_wr(s, d); check_state("R3 R5 R6 R7 random"); end
                2: bus_rd(s, "R2 R8 R9 random read");
                3: begin
                    pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
                    bus_rd(s, "R8 random pins");
                end
                default: begin
                    @(negedge clk); sel = s; din = d; cs_n = 1; wr_n = 0;
                    @(negedge clk); wr_n = 1;
                    check_state("R11 random deselect");
                    #1 chk("R10 random idle", dout, 8'h00);
                end
            endcase
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule